// File: doc/BRIEF.md
# Pixel Color Gain Steering Multiplexer

This block sits in the pixel path of an image sensor front end. For each pixel it puts out one of four programmable 6-bit gain codes, one per colour channel, and the code depends on where that pixel lies in a 2x2 colour filter mosaic. A pixel-advance strobe moves the block from one pixel to the next. A horizontal sync pulse starts a new line and a vertical sync pulse starts a new field. The selected code is registered, so it is aligned to the pixel that was just advanced.

There are two ways to choose between the two register pairs. In mosaic mode the pair follows line parity: even lines alternate between codes 0 and 1, and odd lines alternate between codes 2 and 3. In field-select mode, which suits interlaced sensors, the pair is fixed for a whole field and flips at each vertical sync. Gain inputs are captured into a shadow copy only on a sync pulse, so a line never mixes two settings.

Top module: `pxgain_steer`

## Requirements
- R1: While reset is asserted, and after it is released, `gain_out` is 0. The first field after reset counts as even.
- R2: On an even line, successive pixels output `gain0`, `gain1`, `gain0`, and so on, starting with `gain0` (pair 0 is selected when the pair bit is 0).
- R3: On an odd line, successive pixels output `gain2`, `gain3`, `gain2`, and so on, starting with `gain2`.
- R4: A horizontal sync restarts the alternation, so the first pixel after it uses the even-phase code of the new line's pair, whatever the pixel count of the previous line.
- R5: A vertical sync forces the line that follows to be even. Each horizontal sync that is not accompanied by a vertical sync toggles the line parity.
- R6: When `field_mode` is 1, every line of a field uses the same pair and horizontal syncs do not change it. The first field after reset uses `gain0`/`gain1`, and each vertical sync swaps the pair.
- R7: `gain_out` changes only on the clock edge after a cycle where `pix_en` is 1 and both syncs are 0. A `pix_en` that coincides with a sync pulse is ignored.
- R8: A change on a gain input has no effect until the next sync pulse (horizontal or vertical). Until then, pixels keep the previously captured values.
- R9: Codes are passed through bit for bit. The signed extremes 6'b100000 (minimum gain) and 6'b011111 (maximum gain) appear unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Advance to the next pixel |
| hsync | input | 1 | Line start pulse |
| vsync | input | 1 | Field start pulse, which also starts line 0 |
| field_mode | input | 1 | 0: mosaic (line parity), 1: field-select |
| gain0 | input | 6 | Code for even line, even pixel |
| gain1 | input | 6 | Code for even line, odd pixel |
| gain2 | input | 6 | Code for odd line, even pixel |
| gain3 | input | 6 | Code for odd line, odd pixel |
| gain_out | output | 6 | Registered code for the current pixel |

## Verification
A wrong pixel-phase bit swaps two codes of a pair, and this shows on the first pixel of a line, one cycle after its advance. A stuck line-parity or field bit puts the wrong pair on the first pixel after the next sync. A shadow that is loaded at the wrong time makes an input change visible in the middle of a line. The tests give the four registers distinct codes so that every such slip appears on the very next pixel.

// File: rtl/pxgain_steer.sv
module pxgain_steer #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              field_mode,
  input  logic [CODE_W-1:0] gain0,
  input  logic [CODE_W-1:0] gain1,
  input  logic [CODE_W-1:0] gain2,
  input  logic [CODE_W-1:0] gain3,
  output logic [CODE_W-1:0] gain_out
);
  logic [CODE_W-1:0] sh0, sh1, sh2, sh3, pick;
  logic ph, lp, fld, sync, pair;

  assign sync = hsync | vsync;
  assign pair = field_mode ? fld : lp;

  always_comb
    case ({pair, ph})
      2'b00:   pick = sh0;
      2'b01:   pick = sh1;
      2'b10:   pick = sh2;
      default: pick = sh3;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh0 <= '0; sh1 <= '0; sh2 <= '0; sh3 <= '0;
      ph <= 1'b0; lp <= 1'b0; fld <= 1'b1;
      gain_out <= '0;
    end else begin
      if (sync) begin
        sh0 <= gain0; sh1 <= gain1; sh2 <= gain2; sh3 <= gain3;
        ph <= 1'b0;
      end else if (pix_en) begin
        ph <= ~ph;
        gain_out <= pick;
      end
      if (vsync) begin
        lp  <= 1'b0;
        fld <= ~fld;
      end else if (hsync) begin
        lp <= ~lp;
      end
    end
  end
endmodule

module pxgain_steer_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_en,
  input logic              hsync,
  input logic              vsync,
  input logic              ph,
  input logic              lp,
  input logic              fld,
  input logic [CODE_W-1:0] sh0,
  input logic [CODE_W-1:0] sh1,
  input logic [CODE_W-1:0] sh2,
  input logic [CODE_W-1:0] sh3,
  input logic [CODE_W-1:0] gain_out
);
  a_r7_hold_without_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en || hsync || vsync) |=> $stable(gain_out));

  a_r2_out_from_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !hsync && !vsync) |=>
      (gain_out == sh0 || gain_out == sh1 || gain_out == sh2 || gain_out == sh3));

  a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync || vsync) |=> !ph);

  a_r5_vsync_even_line: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> !lp);

  a_r6_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (fld != $past(fld)));

  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !vsync) |=>
      ($stable(sh0) && $stable(sh1) && $stable(sh2) && $stable(sh3)));
endmodule

bind pxgain_steer pxgain_steer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
  .ph(ph), .lp(lp), .fld(fld),
  .sh0(sh0), .sh1(sh1), .sh2(sh2), .sh3(sh3), .gain_out(gain_out)
);

// File: tb/pxgain_steer_bench.sv
module pxgain_steer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0, hsync = 1'b0, vsync = 1'b0, field_mode = 1'b0;
  logic [5:0] gain0 = 6'h05, gain1 = 6'h0A, gain2 = 6'h20, gain3 = 6'h1F;
  logic [5:0] gain_out;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pxgain_steer u_pxgain_steer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
    .field_mode(field_mode), .gain0(gain0), .gain1(gain1), .gain2(gain2),
    .gain3(gain3), .gain_out(gain_out)
  );

  task automatic check(input logic [5:0] exp, input string req);
    n_cmp++;
    if (gain_out !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, gain_out, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pix_en = 1'b0; hsync = 1'b0; vsync = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sync(input logic h, input logic v);
    @(negedge clk); hsync = h; vsync = v;
    @(negedge clk); hsync = 1'b0; vsync = 1'b0;
  endtask

  task automatic pixel(input logic [5:0] exp, input string req);
    @(negedge clk); pix_en = 1'b1;
    @(negedge clk); pix_en = 1'b0;
    check(exp, req);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check(6'h00, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk); check(6'h00, "R1 after reset");
  endtask

  task automatic t_mosaic();
    field_mode = 1'b0;
    sync(1'b0, 1'b1);
    pixel(gain0, "R2 even px0"); pixel(gain1, "R2 even px1");
    pixel(gain0, "R2 even px2"); pixel(gain1, "R2 even px3");
    sync(1'b1, 1'b0);
    pixel(gain2, "R3 odd px0"); pixel(gain3, "R3 odd px1");
    pixel(6'b100000, "R9 min code"); pixel(6'b011111, "R9 max code");
    sync(1'b1, 1'b0);
    pixel(gain0, "R5 hsync toggles back to even");
  endtask

  task automatic t_restart();
    field_mode = 1'b0;
    sync(1'b0, 1'b1);
    pixel(gain0, "R2 px0"); pixel(gain1, "R2 px1"); pixel(gain0, "R2 px2");
    sync(1'b1, 1'b0);
    pixel(gain2, "R4 restart after odd count");
    pixel(gain3, "R3 odd px1");
    sync(1'b0, 1'b1);
    pixel(gain0, "R5 vsync mid odd line gives even");
    sync(1'b1, 1'b1);
    pixel(gain0, "R5 vsync wins over hsync");
  endtask

  task automatic t_hold();
    field_mode = 1'b0;
    sync(1'b0, 1'b1);
    pixel(gain0, "R2 px0");
    repeat (3) @(negedge clk);
    check(gain0, "R7 idle holds");
    @(negedge clk); pix_en = 1'b1; hsync = 1'b1;
    @(negedge clk); pix_en = 1'b0; hsync = 1'b0;
    check(gain0, "R7 advance during sync ignored");
    pixel(gain2, "R7 next advance starts odd line");
  endtask

  task automatic t_field();
    do_reset();
    field_mode = 1'b1;
    sync(1'b0, 1'b1);
    pixel(gain0, "R6 first field px0"); pixel(gain1, "R6 first field px1");
    sync(1'b1, 1'b0);
    pixel(gain0, "R6 hsync keeps pair");
    sync(1'b1, 1'b0);
    pixel(gain0, "R6 second hsync keeps pair");
    sync(1'b0, 1'b1);
    pixel(gain2, "R6 next field px0"); pixel(gain3, "R6 next field px1");
    sync(1'b1, 1'b0);
    pixel(gain2, "R6 next field line1");
    sync(1'b0, 1'b1);
    pixel(gain0, "R6 third field back to pair0");
    field_mode = 1'b0;
  endtask

  task automatic t_shadow();
    logic [5:0] old0;
    field_mode = 1'b0;
    old0 = gain0;
    sync(1'b0, 1'b1);
    pixel(old0, "R8 px0");
    @(negedge clk); gain0 = 6'h11; gain2 = 6'h2A;
    pixel(gain1, "R8 px1");
    pixel(old0, "R8 old code held mid line");
    sync(1'b1, 1'b0);
    pixel(6'h2A, "R8 new odd code after hsync");
    sync(1'b1, 1'b0);
    pixel(6'h11, "R8 new even code after hsync");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    t_reset();
    t_mosaic();
    t_restart();
    t_hold();
    t_field();
    t_shadow();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule